// File: doc/BRIEF.md
# Multi-Channel Switching Frequency Generator

This block turns one fast system clock into switching-period timing for a set of power-stage channels (four by default). A programmable divide value sets the length of a fundamental period, counted in system clock cycles. Every channel runs at one, two or four times that fundamental rate. Each channel's periods begin at a programmable fraction of its own period after the fundamental period starts, so the channels do not all switch at the same instant.

For every channel the block drives a one-cycle period-start pulse and a free-running count of the position within the current period. A downstream digital PWM compares against these. Because all rates are derived from one base counter, every channel stays phase-locked to the fundamental period. When the reference clock changes, every channel frequency scales with it and the register values stay the same. Configuration writes go into shadow registers and take effect only at the next fundamental period boundary.

Top module: `swfreq_gen`

## Requirements
- R1: The fundamental period lasts exactly P system clock cycles, where P is the effective divide value. A channel set to 1x with phase 0 pulses its start output once every P cycles.
- R2: A divide value that is not a multiple of 16 is rounded down to the next multiple of 16 (for example, 805 gives 800).
- R3: Divide values below 336 are treated as 336. Values above 981 are treated as 981, which rounds to 976.
- R4: A channel's 2-bit multiplier field selects its period length Lc. Code 00 gives P, code 01 gives P/2, and codes 10 and 11 both give P/4. Every channel period is aligned to the fundamental period start.
- R5: A channel's 2-bit phase field ph delays its period starts by ph*Lc/4 cycles relative to the start pulse of a 1x, phase-0 channel.
- R6: A channel's count output is 0 in the cycle its start pulse is high. It then rises by one each cycle up to Lc-1 and wraps back to 0 together with the next start pulse.
- R7: Writes to the divide value or to a channel configuration take effect only at the next fundamental period boundary. The period in progress keeps its length.
- R8: While reset is asserted, all start and count outputs are 0. After reset, the divide value is 512 and every channel is 1x with phase 0, so all channels pulse together.
- R9: Register map. Address 0 holds the divide value in wr_data[9:0]. Addresses 1 to 4 hold the configuration of channels 0 to 3: multiplier in wr_data[1:0] and phase in wr_data[3:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 = divide, 1..4 = channel config) |
| wr_data | input | 10 | Write data |
| ch_start | output | 4 | Per-channel period-start pulse |
| ch_count | output | 40 | Per-channel period position, 10 bits per channel, channel 0 in the low bits |

## Verification
A write lands in the shadow register on the next edge. It becomes active on the edge where the base counter wraps, and the channel outputs follow one registered stage later. For this reason the bench never measures a new setting until two start pulses of the reference channel have passed after the write. Periods and phase offsets are measured as numbers of falling edges between start pulses, so the fixed output register delay cancels out. The shadow test writes in the middle of a period and expects the old period length for that interval and the new length for the next one. Count values are compared cycle by cycle against a running index that the bench starts at a start pulse.

// File: rtl/swfreq_pkg.sv
package swfreq_pkg;

  typedef enum logic [1:0] {
    MUL_X1  = 2'd0,
    MUL_X2  = 2'd1,
    MUL_X4  = 2'd2,
    MUL_X4B = 2'd3
  } mul_e;

  // phase in upper bits, multiplier in lower bits (matches write data [3:0])
  typedef struct packed {
    logic [1:0] phase;
    mul_e       mul;
  } chcfg_t;

endpackage

// File: rtl/swfreq_regs.sv
module swfreq_regs
  import swfreq_pkg::*;
#(
  parameter int DIV_W   = 10,
  parameter int NCH     = 4,
  parameter int AW      = 3,
  parameter int DIV_MIN = 336,
  parameter int DIV_MAX = 981,
  parameter int DIV_RST = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DIV_W-1:0]      wr_data,
  input  logic                  load,
  output logic [DIV_W-1:0]      act_period,
  output chcfg_t [NCH-1:0]      act_cfg
);

  localparam logic [DIV_W-1:0] LO  = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI  = DIV_W'(DIV_MAX);
  localparam logic [DIV_W-1:0] RST = DIV_W'((DIV_RST / 16) * 16);

  logic [DIV_W-1:0] sh_div_q, sh_div_d, clamped, limited;
  chcfg_t [NCH-1:0] sh_cfg_q, sh_cfg_d;

  // clamp to range, then round down to a multiple of 16
  always_comb begin
    if (wr_data < LO)      limited = LO;
    else if (wr_data > HI) limited = HI;
    else                   limited = wr_data;
    clamped = {limited[DIV_W-1:4], 4'b0000};
  end

  always_comb begin
    sh_div_d = sh_div_q;
    sh_cfg_d = sh_cfg_q;
    if (wr_en) begin
      if (wr_addr == '0) sh_div_d = clamped;
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == AW'(i + 1)) sh_cfg_d[i] = chcfg_t'(wr_data[3:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div_q <= RST;
      sh_cfg_q <= '0;
    end else begin
      sh_div_q <= sh_div_d;
      sh_cfg_q <= sh_cfg_d;
    end
  end

  // active copy, enabled only at the base period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= RST;
      act_cfg    <= '0;
    end else if (load) begin
      act_period <= sh_div_q;
      act_cfg    <= sh_cfg_q;
    end
  end

  a_r3_active_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (act_period >= LO) && (act_period <= HI) && (act_period[3:0] == 4'd0));

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_period) && $stable(act_cfg)));

endmodule

// File: rtl/swfreq_base.sv
module swfreq_base #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] period,
  output logic [DIV_W-1:0] cnt,
  output logic             wrap
);

  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    wrap  = (cnt == period - DIV_W'(1));
    cnt_d = wrap ? '0 : cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period);

  a_r1_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/swfreq_chan.sv
module swfreq_chan
  import swfreq_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cnt,
  input  logic [DIV_W-1:0] period,
  input  chcfg_t           cfg,
  output logic             start,
  output logic [DIV_W-1:0] pcnt
);

  logic [DIV_W-1:0] len, quarter, off, pos, rel;
  logic             start_d;

  always_comb begin
    case (cfg.mul)
      MUL_X1:  len = period;
      MUL_X2:  len = period >> 1;
      default: len = period >> 2;
    endcase
    quarter = len >> 2;
    case (cfg.phase)
      2'd0:    off = '0;
      2'd1:    off = quarter;
      2'd2:    off = quarter << 1;
      default: off = quarter + (quarter << 1);
    endcase
    // position of the base count inside this channel's period
    pos = cnt;
    for (int k = 0; k < 3; k++) begin
      if (pos >= len) pos = pos - len;
    end
    rel     = (pos >= off) ? pos - off : pos + len - off;
    start_d = (pos == off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= 1'b0;
      pcnt  <= '0;
    end else begin
      start <= start_d;
      pcnt  <= rel;
    end
  end

  a_r6_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (pcnt == '0));

endmodule

// File: rtl/swfreq_gen.sv
module swfreq_gen
  import swfreq_pkg::*;
#(
  parameter int DIV_W   = 10,
  parameter int NCH     = 4,
  parameter int DIV_MIN = 336,
  parameter int DIV_MAX = 981,
  parameter int DIV_RST = 512,
  localparam int AW     = $clog2(NCH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DIV_W-1:0]       wr_data,
  output logic [NCH-1:0]         ch_start,
  output logic [NCH*DIV_W-1:0]   ch_count
);

  logic             rst_m, rst_s;
  logic [DIV_W-1:0] period, cnt;
  logic             wrap;
  chcfg_t [NCH-1:0] cfg;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  swfreq_regs #(
    .DIV_W(DIV_W), .NCH(NCH), .AW(AW),
    .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(wrap), .act_period(period), .act_cfg(cfg)
  );

  swfreq_base #(.DIV_W(DIV_W)) u_base (
    .clk(clk), .rst_n(rst_s), .period(period), .cnt(cnt), .wrap(wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    swfreq_chan #(.DIV_W(DIV_W)) u_ch (
      .clk(clk), .rst_n(rst_s), .cnt(cnt), .period(period), .cfg(cfg[g]),
      .start(ch_start[g]), .pcnt(ch_count[g*DIV_W +: DIV_W])
    );
  end

endmodule

// File: tb/sim_swfreq_gen.sv
module sim_swfreq_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [9:0]  wr_data;
  logic [3:0]  ch_start;
  logic [39:0] ch_count;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  swfreq_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_start(ch_start), .ch_count(ch_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse(input int ch);
    do @(negedge clk); while (!ch_start[ch]);
  endtask

  task automatic settle();
    wait_pulse(0);
    wait_pulse(0);
  endtask

  task automatic period_of(input int ch, output int len);
    wait_pulse(ch);
    len = 0;
    do begin @(negedge clk); len++; end while (!ch_start[ch]);
  endtask

  task automatic offset_of(input int ch, output int off);
    wait_pulse(0);
    off = 0;
    while (!ch_start[ch]) begin @(negedge clk); off++; end
  endtask

  // R8: reset state and defaults
  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    check(ch_start == 4'b0 && ch_count == '0, "R8 reset outputs", int'(ch_start), 0);
    rst_n = 1'b1;
    do @(negedge clk); while (ch_start == 4'b0);
    check(ch_start == 4'b1111, "R8 default channels aligned", int'(ch_start), 15);
  endtask

  // R1: default and programmed period
  task automatic t_period();
    int len;
    period_of(0, len);
    check(len == 512, "R1 default period", len, 512);
    wr(3'd0, 10'd800); settle();
    period_of(0, len);
    check(len == 800, "R1 R9 programmed period", len, 800);
  endtask

  // R2, R3: rounding and clamping
  task automatic t_limits();
    int len;
    wr(3'd0, 10'd805); settle(); period_of(0, len);
    check(len == 800, "R2 round down", len, 800);
    wr(3'd0, 10'd100); settle(); period_of(0, len);
    check(len == 336, "R3 clamp low", len, 336);
    wr(3'd0, 10'd1023); settle(); period_of(0, len);
    check(len == 976, "R3 clamp high", len, 976);
    wr(3'd0, 10'd512); settle();
  endtask

  // R4: multiplier selection
  task automatic t_mult();
    int len;
    wr(3'd2, 10'b0001); wr(3'd3, 10'b0010); wr(3'd4, 10'b0011); settle();
    period_of(1, len); check(len == 256, "R4 2x period", len, 256);
    period_of(2, len); check(len == 128, "R4 4x period", len, 128);
    period_of(3, len); check(len == 128, "R4 code 11 is 4x", len, 128);
  endtask

  // R5: phase offsets
  task automatic t_phase();
    int off;
    wr(3'd2, 10'b1000); wr(3'd3, 10'b0101); wr(3'd4, 10'b1110); settle();
    offset_of(1, off); check(off == 256, "R5 1x half offset", off, 256);
    offset_of(2, off); check(off == 64, "R5 2x quarter offset", off, 64);
    offset_of(3, off); check(off == 96, "R5 4x three-quarter offset", off, 96);
  endtask

  // R6: count sequence of the 4x channel (length 128)
  task automatic t_count();
    int errs = 0;
    int first_bad = -1;
    wait_pulse(3);
    if (ch_count[39:30] != 10'd0) errs++;
    for (int k = 1; k < 128; k++) begin
      @(negedge clk);
      if (ch_count[39:30] != 10'(k) || ch_start[3]) begin
        errs++;
        if (first_bad < 0) first_bad = int'(ch_count[39:30]);
      end
    end
    check(errs == 0, "R6 count ramp", first_bad, 0);
    @(negedge clk);
    check(ch_start[3] && ch_count[39:30] == 10'd0, "R6 wrap with start",
          int'(ch_count[39:30]), 0);
  endtask

  // R7: shadowed write mid-period
  task automatic t_shadow();
    int len;
    wait_pulse(0);
    repeat (100) @(negedge clk);
    wr(3'd0, 10'd640);
    len = 102;
    do begin @(negedge clk); len++; end while (!ch_start[0]);
    check(len == 512, "R7 current period kept", len, 512);
    len = 0;
    do begin @(negedge clk); len++; end while (!ch_start[0]);
    check(len == 640, "R7 new period at boundary", len, 640);
  endtask

  initial begin
    t_reset();
    t_period();
    t_limits();
    t_mult();
    t_phase();
    t_count();
    t_shadow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog all act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule